// File: doc/BRIEF.md
# Function-Coded Integer ALU with Hi/Lo Registers

This block is a 16-bit integer arithmetic unit. A 6-bit function code picks one of seven operations: add, subtract, bitwise AND, bitwise OR, logical left shift, unsigned multiply and unsigned divide. Each operation feeds a single result multiplexer, and the result is combinational from the inputs in the same cycle. The multiplier and the divider are both full-width combinational arrays, so they sit in the same multiplexer as the simple operations.

A multiply or divide produces two words. The low word (the lower product half or the quotient) appears on the result output at once. Both words are also captured at the next rising clock edge: the upper product half or the remainder goes into the hi register, and the low word goes into the lo register. Any other function code leaves both registers unchanged. Surrounding control logic can move the hi and lo values on a later cycle.

Top module: `fcode_alu`

## Requirements
- R1: Code 6'b100000 gives `result` = (a + b) mod 2^16 in the same cycle.
- R2: Code 6'b100010 gives `result` = (a - b) mod 2^16 in the same cycle.
- R3: Code 6'b100100 gives `result` = a & b. Code 6'b100101 gives `result` = a | b.
- R4: Code 6'b000010 gives `result` = a shifted left by `shamt` places (0 to 15), with zeros shifted in.
- R5: Code 6'b011000 gives `result` = low 16 bits of the unsigned product a*b. At the next rising edge, `lo_q` takes the low 16 bits and `hi_q` takes the high 16 bits.
- R6: Code 6'b011010 gives `result` = unsigned quotient a/b. At the next rising edge, `lo_q` takes the quotient and `hi_q` takes the remainder a mod b.
- R7: Divide with b = 0 gives quotient 16'hFFFF on `result` and `lo_q`, and remainder a on `hi_q`.
- R8: Any code not listed in R1 to R6 gives `result` = 0.
- R9: A rising edge with a code other than multiply or divide leaves `hi_q` and `lo_q` unchanged.
- R10: A rising edge with `rst` high clears `hi_q` and `lo_q` to 0. This takes priority over a multiply or divide code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opnd_a | input | 16 | First operand (dividend, value to shift) |
| opnd_b | input | 16 | Second operand (divisor) |
| shamt | input | 4 | Left shift distance |
| fcode | input | 6 | Function code |
| result | output | 16 | Combinational result |
| hi_q | output | 16 | High product word or remainder |
| lo_q | output | 16 | Low product word or quotient |

## Verification
The only state in the block is the hi/lo register pair. A fault there shows up one edge after the operation that should have loaded it, as a wrong or stale `hi_q`/`lo_q` value. The bench reads the registers after each multiply and divide. It also reads them again after simple operations and unlisted codes, so that a stray load is seen on the next edge. A fault in the result multiplexer or in an arithmetic array shows up on `result` in the same cycle, before any edge, so every operation is checked combinationally first.

// File: rtl/fcode_alu.sv
module fcode_alu #(
  parameter int W  = 16,
  parameter int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  input  logic [SW-1:0] shamt,
  input  logic [5:0]    fcode,
  output logic [W-1:0]  result,
  output logic [W-1:0]  hi_q,
  output logic [W-1:0]  lo_q
);
  localparam logic [5:0] F_ADD = 6'b100000;
  localparam logic [5:0] F_SUB = 6'b100010;
  localparam logic [5:0] F_AND = 6'b100100;
  localparam logic [5:0] F_OR  = 6'b100101;
  localparam logic [5:0] F_SLL = 6'b000010;
  localparam logic [5:0] F_MUL = 6'b011000;
  localparam logic [5:0] F_DIV = 6'b011010;

  logic [2*W-1:0] prod;
  logic [W-1:0]   quot, rem;
  logic           div0;

  assign prod = {{W{1'b0}}, opnd_a} * {{W{1'b0}}, opnd_b};
  assign div0 = (opnd_b == '0);
  assign quot = div0 ? '1 : opnd_a / opnd_b;
  assign rem  = div0 ? opnd_a : opnd_a % opnd_b;

  always_comb begin
    case (fcode)
      F_ADD:   result = opnd_a + opnd_b;
      F_SUB:   result = opnd_a - opnd_b;
      F_AND:   result = opnd_a & opnd_b;
      F_OR:    result = opnd_a | opnd_b;
      F_SLL:   result = opnd_a << shamt;
      F_MUL:   result = prod[W-1:0];
      F_DIV:   result = quot;
      default: result = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (fcode == F_MUL) begin
      hi_q <= prod[2*W-1:W];
      lo_q <= prod[W-1:0];
    end else if (fcode == F_DIV) begin
      hi_q <= rem;
      lo_q <= quot;
    end
  end

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (hi_q == '0 && lo_q == '0));

  assert_mul_lo_matches_R5: assert property (@(posedge clk) disable iff (rst)
    fcode == F_MUL |=> lo_q == $past(result));

  assert_div_lo_matches_R6: assert property (@(posedge clk) disable iff (rst)
    fcode == F_DIV |=> lo_q == $past(result));

  assert_div_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (fcode == F_DIV && opnd_b == '0) |=> (lo_q == '1 && hi_q == $past(opnd_a)));

  assert_hold_other_R9: assert property (@(posedge clk) disable iff (rst)
    (fcode != F_MUL && fcode != F_DIV) |=> ($stable(hi_q) && $stable(lo_q)));

  assert_unlisted_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (fcode != F_ADD && fcode != F_SUB && fcode != F_AND && fcode != F_OR &&
     fcode != F_SLL && fcode != F_MUL && fcode != F_DIV) |-> result == '0);
endmodule

// File: tb/fcode_alu_bench.sv
module fcode_alu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a = '0, b = '0;
  logic [3:0]  sh = '0;
  logic [5:0]  fc = '0;
  logic [15:0] result, hi_q, lo_q;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fcode_alu u_fcode_alu (.clk(clk), .rst(rst), .opnd_a(a), .opnd_b(b), .shamt(sh),
                         .fcode(fc), .result(result), .hi_q(hi_q), .lo_q(lo_q));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [5:0] f, logic [15:0] x, logic [15:0] y, logic [3:0] s);
    @(negedge clk);
    fc = f; a = x; b = y; sh = s;
    #1;
  endtask

  task automatic after_edge();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst = 1'b1; fc = 6'b011000; a = 16'h1234; b = 16'h5678;
    repeat (2) @(posedge clk); #1;
    chk("R10 hi after reset", hi_q, 16'h0);
    chk("R10 lo after reset", lo_q, 16'h0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_simple();
    drive(6'b100000, 16'hFFFF, 16'h0002, 0); chk("R1 add wrap", result, 16'h0001);
    drive(6'b100000, 16'h1234, 16'h4321, 0); chk("R1 add", result, 16'h5555);
    drive(6'b100010, 16'h0003, 16'h0005, 0); chk("R2 sub borrow", result, 16'hFFFE);
    drive(6'b100010, 16'h9000, 16'h1001, 0); chk("R2 sub", result, 16'h7FFF);
    drive(6'b100100, 16'hF0F0, 16'hFF00, 0); chk("R3 and", result, 16'hF000);
    drive(6'b100101, 16'hF0F0, 16'h0F0F, 0); chk("R3 or", result, 16'hFFFF);
    drive(6'b000010, 16'h8001, 16'hFFFF, 0); chk("R4 sll 0", result, 16'h8001);
    drive(6'b000010, 16'h8001, 16'h0, 1);    chk("R4 sll 1", result, 16'h0002);
    drive(6'b000010, 16'hFFFF, 16'h0, 15);   chk("R4 sll 15", result, 16'h8000);
  endtask

  task automatic t_mul(logic [15:0] x, logic [15:0] y);
    logic [31:0] p;
    p = {16'h0, x} * {16'h0, y};
    drive(6'b011000, x, y, 0);
    chk("R5 mul result", result, p[15:0]);
    after_edge();
    chk("R5 mul hi", hi_q, p[31:16]);
    chk("R5 mul lo", lo_q, p[15:0]);
  endtask

  task automatic t_div(logic [15:0] x, logic [15:0] y, string req);
    logic [15:0] q, r;
    q = (y == 0) ? 16'hFFFF : x / y;
    r = (y == 0) ? x : x % y;
    drive(6'b011010, x, y, 0);
    chk({req, " div result"}, result, q);
    after_edge();
    chk({req, " div hi"}, hi_q, r);
    chk({req, " div lo"}, lo_q, q);
  endtask

  task automatic t_hold();
    logic [15:0] h, l;
    h = hi_q; l = lo_q;
    drive(6'b100000, 16'h1111, 16'h2222, 3); after_edge();
    chk("R9 hi held after add", hi_q, h);
    chk("R9 lo held after add", lo_q, l);
    drive(6'b111111, 16'hABCD, 16'h1234, 5);
    chk("R8 unlisted result", result, 16'h0);
    after_edge();
    chk("R8 hi held unlisted", hi_q, h);
    chk("R8 lo held unlisted", lo_q, l);
    drive(6'b011001, 16'hABCD, 16'h1234, 0);
    chk("R8 near-mul code zero", result, 16'h0);
  endtask

  initial begin
    t_reset();
    t_simple();
    t_mul(16'hFFFF, 16'hFFFF);
    t_mul(16'h1234, 16'h0100);
    t_hold();
    t_div(16'd1000, 16'd7, "R6");
    t_div(16'h0005, 16'h0009, "R6");
    t_div(16'hBEEF, 16'h0000, "R7");
    t_hold();
    t_mul(16'h00FF, 16'h0101);
    t_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule